// File: doc/BRIEF.md
# Byte-Serial Command to AXI Master Bridge

This block turns a stream of 8-bit command bytes, as delivered by an SPI slave deserializer, into memory-mapped bus traffic. Each command opens with an opcode byte that picks one of two master ports: a full AXI4 port that carries incrementing bursts, or an AXI4-Lite port that carries one word. The opcode is followed by a 32-bit target address, a length byte and, for writes, the data words. The bridge drives the selected port, waits for the response and then accepts the next command.

Read data comes back on an 8-bit output stream, one word at a time, most significant byte first. Because an SPI master only receives while it transmits, the external master clocks filler bytes to collect the read bytes. The bridge holds its bus read channel off while its output byte buffer is occupied, so slow draining on the SPI side never drops a beat. A non-OKAY write response sets a sticky error output.

Top module: `bytecmd_axi_bridge`

## Requirements
- R1: Opcode 0x01 is a single write on the Lite port, 0x02 a single read on the Lite port, 0x03 a burst write on the AXI4 port and 0x04 a burst read on the AXI4 port. Any other first byte is dropped, and the bridge keeps waiting for an opcode.
- R2: The four bytes after the opcode form the address, most significant byte first. One length byte follows. For writes, each 32-bit data word then follows as four bytes, most significant byte first.
- R3: A Lite write issues exactly one AW and one W transfer on the Lite port with all write strobes set. The length byte of a Lite command is ignored, and exactly one data word follows it.
- R4: A Lite read issues exactly one AR transfer on the Lite port and returns the word as four output bytes, most significant byte first.
- R5: A burst write presents AWLEN equal to the length byte, AWBURST = 01 (incrementing) and AWSIZE = 2 (4 bytes). It sends length+1 W beats with all strobes set and WLAST high on the final beat only. A length of 0 gives one beat.
- R6: A burst read presents ARLEN equal to the length byte, ARBURST = 01 and ARSIZE = 2. All length+1 returned beats appear on the output stream in beat order, each as four bytes, most significant first.
- R7: The input stream's TREADY is low from the end of a command's input bytes until its bus transaction completes (write response taken, or last read beat taken).
- R8: RREADY on either port is low while the output byte buffer still holds bytes that will not leave in the current cycle. An output byte held by back-pressure stays stable, and no read beat is lost.
- R9: A write response other than OKAY (BRESP != 00) sets the error output. The output then stays set, through later successful commands, until reset.
- R10: After reset no master valid is asserted, the output stream is empty, the input stream is ready and the error output is low.
- R11: A command never produces handshakes on the port its opcode did not select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 8 | Command byte stream data |
| s_tvalid | input | 1 | Command byte valid |
| s_tready | output | 1 | Command byte accepted |
| m_tdata | output | 8 | Read-return byte stream data |
| m_tvalid | output | 1 | Read-return byte valid |
| m_tready | input | 1 | Read-return byte taken |
| err_flag | output | 1 | Sticky write-response error |
| m4_awaddr | output | ADDR_W | AXI4 write address |
| m4_awlen | output | LEN_W | AXI4 write burst length |
| m4_awsize | output | 3 | AXI4 write beat size |
| m4_awburst | output | 2 | AXI4 write burst type |
| m4_awvalid | output | 1 | AXI4 write address valid |
| m4_awready | input | 1 | AXI4 write address ready |
| m4_wdata | output | DATA_W | AXI4 write data |
| m4_wstrb | output | DATA_W/8 | AXI4 write strobes |
| m4_wlast | output | 1 | AXI4 final write beat |
| m4_wvalid | output | 1 | AXI4 write data valid |
| m4_wready | input | 1 | AXI4 write data ready |
| m4_bresp | input | 2 | AXI4 write response |
| m4_bvalid | input | 1 | AXI4 write response valid |
| m4_bready | output | 1 | AXI4 write response ready |
| m4_araddr | output | ADDR_W | AXI4 read address |
| m4_arlen | output | LEN_W | AXI4 read burst length |
| m4_arsize | output | 3 | AXI4 read beat size |
| m4_arburst | output | 2 | AXI4 read burst type |
| m4_arvalid | output | 1 | AXI4 read address valid |
| m4_arready | input | 1 | AXI4 read address ready |
| m4_rdata | input | DATA_W | AXI4 read data |
| m4_rlast | input | 1 | AXI4 final read beat |
| m4_rvalid | input | 1 | AXI4 read data valid |
| m4_rready | output | 1 | AXI4 read data ready |
| ml_awaddr | output | ADDR_W | Lite write address |
| ml_awvalid | output | 1 | Lite write address valid |
| ml_awready | input | 1 | Lite write address ready |
| ml_wdata | output | DATA_W | Lite write data |
| ml_wstrb | output | DATA_W/8 | Lite write strobes |
| ml_wvalid | output | 1 | Lite write data valid |
| ml_wready | input | 1 | Lite write data ready |
| ml_bresp | input | 2 | Lite write response |
| ml_bvalid | input | 1 | Lite write response valid |
| ml_bready | output | 1 | Lite write response ready |
| ml_araddr | output | ADDR_W | Lite read address |
| ml_arvalid | output | 1 | Lite read address valid |
| ml_arready | input | 1 | Lite read address ready |
| ml_rdata | input | DATA_W | Lite read data |
| ml_rvalid | input | 1 | Lite read data valid |
| ml_rready | output | 1 | Lite read data ready |

## Verification
Two functions can land on the same clock edge. The output buffer can hand out the last byte of one read word on the same edge that it loads the next read beat. The parser can also start taking a new command while the previous read's bytes are still draining. The bench provokes both with bus slaves that hold RVALID high and a byte-stream sink whose TREADY is held low, toggled or held high. It also issues a second read header right after the first, without draining between them. A scoreboard, filled in command order, compares every output byte, so a lost, repeated or reordered byte from a mistimed reload shows up as a miscompare.

// File: rtl/bcab_pkg.sv
package bcab_pkg;
  // opcode values carried by the first byte of every command
  localparam logic [7:0] OP_LITE_WR  = 8'h01;
  localparam logic [7:0] OP_LITE_RD  = 8'h02;
  localparam logic [7:0] OP_BURST_WR = 8'h03;
  localparam logic [7:0] OP_BURST_RD = 8'h04;

  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef enum logic [2:0] {P_OPC, P_ADDR, P_LEN, P_DATA, P_WAIT} pstate_e;
  typedef enum logic [2:0] {E_IDLE, E_WR, E_WRESP, E_RADDR, E_RDATA} estate_e;
endpackage

// File: rtl/bcab_cmd_parser.sv
module bcab_cmd_parser
  import bcab_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic              cmd_valid,
  output logic              cmd_lite,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  input  logic              word_ready,
  input  logic              eng_done
);
  localparam int BPW = DATA_W / 8;
  localparam int ABY = ADDR_W / 8;
  localparam int CW  = $clog2((BPW > ABY ? BPW : ABY) + 1);

  pstate_e             st;
  logic [CW-1:0]       bcnt;
  logic [LEN_W-1:0]    wcnt;
  logic [DATA_W-9:0]   shreg;
  logic                hs;

  always_comb begin
    case (st)
      P_DATA:  s_tready = !word_valid;
      P_WAIT:  s_tready = 1'b0;
      default: s_tready = 1'b1;
    endcase
  end

  assign hs = s_tvalid && s_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= P_OPC;
      bcnt       <= '0;
      wcnt       <= '0;
      shreg      <= '0;
      cmd_valid  <= 1'b0;
      cmd_lite   <= 1'b0;
      cmd_rd     <= 1'b0;
      cmd_addr   <= '0;
      cmd_len    <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (word_valid && word_ready) word_valid <= 1'b0;
      case (st)
        P_OPC: if (hs) begin
          bcnt <= '0;
          if (s_tdata == OP_LITE_WR || s_tdata == OP_LITE_RD ||
              s_tdata == OP_BURST_WR || s_tdata == OP_BURST_RD) begin
            cmd_lite <= (s_tdata == OP_LITE_WR) || (s_tdata == OP_LITE_RD);
            cmd_rd   <= (s_tdata == OP_LITE_RD) || (s_tdata == OP_BURST_RD);
            st       <= P_ADDR;
          end
        end
        P_ADDR: if (hs) begin
          cmd_addr <= {cmd_addr[ADDR_W-9:0], s_tdata};
          bcnt     <= bcnt + 1'b1;
          if (bcnt == CW'(ABY - 1)) st <= P_LEN;
        end
        P_LEN: if (hs) begin
          // single transfers always move one word, whatever the byte says
          cmd_len   <= cmd_lite ? '0 : s_tdata[LEN_W-1:0];
          cmd_valid <= 1'b1;
          bcnt      <= '0;
          wcnt      <= '0;
          st        <= cmd_rd ? P_WAIT : P_DATA;
        end
        P_DATA: if (hs) begin
          shreg <= {shreg[DATA_W-17:0], s_tdata};
          bcnt  <= bcnt + 1'b1;
          if (bcnt == CW'(BPW - 1)) begin
            word_data  <= {shreg, s_tdata};
            word_valid <= 1'b1;
            bcnt       <= '0;
            wcnt       <= wcnt + 1'b1;
            if (wcnt == cmd_len) st <= P_WAIT;
          end
        end
        P_WAIT: if (eng_done) st <= P_OPC;
        default: st <= P_OPC;
      endcase
    end
  end

  p_word_not_overwritten_r2: assert property (@(posedge clk) disable iff (rst)
    word_valid && !word_ready |=> word_valid && $stable(word_data));
endmodule

// File: rtl/bcab_axi_engine.sv
module bcab_axi_engine
  import bcab_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_lite,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  output logic              word_ready,
  output logic              done,
  output logic              err,
  output logic              lite_sel,
  output logic [ADDR_W-1:0] ax_addr,
  output logic [LEN_W-1:0]  ax_len,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic              w_valid,
  output logic              w_last,
  output logic [DATA_W-1:0] w_data,
  input  logic              w_ready,
  input  logic              b_valid,
  input  logic [1:0]        b_resp,
  output logic              b_ready,
  output logic              ar_valid,
  input  logic              ar_ready,
  input  logic              r_valid,
  input  logic              r_last,
  input  logic [DATA_W-1:0] r_data,
  output logic              r_ready,
  input  logic              ser_ready,
  output logic              ser_load,
  output logic [DATA_W-1:0] ser_data
);
  estate_e          st;
  logic [LEN_W-1:0] cnt;
  logic             aw_done;
  logic             w_all;

  assign word_ready = (st == E_WR) && !w_valid && !w_all;
  assign b_ready    = (st == E_WRESP);
  assign r_ready    = (st == E_RDATA) && ser_ready;
  assign ser_load   = r_valid && r_ready;
  assign ser_data   = r_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      cnt      <= '0;
      aw_done  <= 1'b0;
      w_all    <= 1'b0;
      aw_valid <= 1'b0;
      ar_valid <= 1'b0;
      w_valid  <= 1'b0;
      w_last   <= 1'b0;
      w_data   <= '0;
      lite_sel <= 1'b0;
      ax_addr  <= '0;
      ax_len   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: if (cmd_valid) begin
          lite_sel <= cmd_lite;
          ax_addr  <= cmd_addr;
          ax_len   <= cmd_len;
          cnt      <= '0;
          aw_done  <= 1'b0;
          w_all    <= 1'b0;
          if (cmd_rd) begin
            ar_valid <= 1'b1;
            st       <= E_RADDR;
          end else begin
            aw_valid <= 1'b1;
            st       <= E_WR;
          end
        end
        E_WR: begin
          if (aw_valid && aw_ready) begin
            aw_valid <= 1'b0;
            aw_done  <= 1'b1;
          end
          if (word_valid && word_ready) begin
            w_data  <= word_data;
            w_valid <= 1'b1;
            w_last  <= (cnt == ax_len);
          end
          if (w_valid && w_ready) begin
            w_valid <= 1'b0;
            cnt     <= cnt + 1'b1;
            if (w_last) w_all <= 1'b1;
          end
          if (aw_done && w_all) st <= E_WRESP;
        end
        E_WRESP: if (b_valid) begin
          if (b_resp != 2'b00) err <= 1'b1;
          done <= 1'b1;
          st   <= E_IDLE;
        end
        E_RADDR: if (ar_ready) begin
          ar_valid <= 1'b0;
          st       <= E_RDATA;
        end
        E_RDATA: if (r_valid && r_ready && (lite_sel || r_last)) begin
          done <= 1'b1;
          st   <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  p_w_hold_r5: assert property (@(posedge clk) disable iff (rst)
    w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_last));
  p_cmd_only_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> st == E_IDLE);
endmodule

// File: rtl/bcab_rd_serializer.sv
module bcab_rd_serializer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic              ready,
  output logic [7:0]        m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready
);
  localparam int BPW = DATA_W / 8;
  localparam int CW  = $clog2(BPW + 1);

  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     left;

  // free now, or free once the last byte leaves on this edge
  assign ready    = (left == '0) || (left == CW'(1) && m_tready);
  assign m_tvalid = (left != '0);
  assign m_tdata  = sh[DATA_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= data;
      left <= CW'(BPW);
    end else if (m_tvalid && m_tready) begin
      sh   <= {sh[DATA_W-9:0], 8'h00};
      left <= left - 1'b1;
    end
  end

  p_hold_under_backpressure_r8: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata));
endmodule

// File: rtl/bytecmd_axi_bridge.sv
module bytecmd_axi_bridge
  import bcab_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          s_tdata,
  input  logic                s_tvalid,
  output logic                s_tready,
  output logic [7:0]          m_tdata,
  output logic                m_tvalid,
  input  logic                m_tready,
  output logic                err_flag,
  output logic [ADDR_W-1:0]   m4_awaddr,
  output logic [LEN_W-1:0]    m4_awlen,
  output logic [2:0]          m4_awsize,
  output logic [1:0]          m4_awburst,
  output logic                m4_awvalid,
  input  logic                m4_awready,
  output logic [DATA_W-1:0]   m4_wdata,
  output logic [DATA_W/8-1:0] m4_wstrb,
  output logic                m4_wlast,
  output logic                m4_wvalid,
  input  logic                m4_wready,
  input  logic [1:0]          m4_bresp,
  input  logic                m4_bvalid,
  output logic                m4_bready,
  output logic [ADDR_W-1:0]   m4_araddr,
  output logic [LEN_W-1:0]    m4_arlen,
  output logic [2:0]          m4_arsize,
  output logic [1:0]          m4_arburst,
  output logic                m4_arvalid,
  input  logic                m4_arready,
  input  logic [DATA_W-1:0]   m4_rdata,
  input  logic                m4_rlast,
  input  logic                m4_rvalid,
  output logic                m4_rready,
  output logic [ADDR_W-1:0]   ml_awaddr,
  output logic                ml_awvalid,
  input  logic                ml_awready,
  output logic [DATA_W-1:0]   ml_wdata,
  output logic [DATA_W/8-1:0] ml_wstrb,
  output logic                ml_wvalid,
  input  logic                ml_wready,
  input  logic [1:0]          ml_bresp,
  input  logic                ml_bvalid,
  output logic                ml_bready,
  output logic [ADDR_W-1:0]   ml_araddr,
  output logic                ml_arvalid,
  input  logic                ml_arready,
  input  logic [DATA_W-1:0]   ml_rdata,
  input  logic                ml_rvalid,
  output logic                ml_rready
);
  localparam int             STRB_W = DATA_W / 8;
  localparam logic [2:0]     AXSIZE = 3'($clog2(STRB_W));

  logic              cmd_valid, cmd_lite, cmd_rd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic              word_valid, word_ready;
  logic [DATA_W-1:0] word_data;
  logic              eng_done, lite;
  logic [ADDR_W-1:0] ax_addr;
  logic [LEN_W-1:0]  ax_len;
  logic              aw_valid, w_valid, w_last, b_ready, ar_valid, r_ready;
  logic [DATA_W-1:0] w_data;
  logic              aw_ready, w_ready, b_valid, ar_ready, r_valid, r_last;
  logic [1:0]        b_resp;
  logic [DATA_W-1:0] r_data;
  logic              ser_ready, ser_load;
  logic [DATA_W-1:0] ser_data;

  bcab_cmd_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_parser (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .cmd_valid(cmd_valid), .cmd_lite(cmd_lite), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .eng_done(eng_done));

  bcab_axi_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_lite(cmd_lite), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .done(eng_done), .err(err_flag),
    .lite_sel(lite), .ax_addr(ax_addr), .ax_len(ax_len), .aw_valid(aw_valid),
    .aw_ready(aw_ready), .w_valid(w_valid), .w_last(w_last), .w_data(w_data),
    .w_ready(w_ready), .b_valid(b_valid), .b_resp(b_resp), .b_ready(b_ready),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .r_valid(r_valid), .r_last(r_last),
    .r_data(r_data), .r_ready(r_ready), .ser_ready(ser_ready), .ser_load(ser_load),
    .ser_data(ser_data));

  bcab_rd_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .data(ser_data), .ready(ser_ready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready));

  // route the shared engine channels to the selected port
  assign aw_ready = lite ? ml_awready : m4_awready;
  assign w_ready  = lite ? ml_wready  : m4_wready;
  assign b_valid  = lite ? ml_bvalid  : m4_bvalid;
  assign b_resp   = lite ? ml_bresp   : m4_bresp;
  assign ar_ready = lite ? ml_arready : m4_arready;
  assign r_valid  = lite ? ml_rvalid  : m4_rvalid;
  assign r_data   = lite ? ml_rdata   : m4_rdata;
  assign r_last   = lite ? 1'b1       : m4_rlast;

  assign m4_awaddr  = ax_addr;
  assign m4_awlen   = ax_len;
  assign m4_awsize  = AXSIZE;
  assign m4_awburst = BURST_INCR;
  assign m4_awvalid = aw_valid && !lite;
  assign m4_wdata   = w_data;
  assign m4_wstrb   = '1;
  assign m4_wlast   = w_last;
  assign m4_wvalid  = w_valid && !lite;
  assign m4_bready  = b_ready && !lite;
  assign m4_araddr  = ax_addr;
  assign m4_arlen   = ax_len;
  assign m4_arsize  = AXSIZE;
  assign m4_arburst = BURST_INCR;
  assign m4_arvalid = ar_valid && !lite;
  assign m4_rready  = r_ready && !lite;

  assign ml_awaddr  = ax_addr;
  assign ml_awvalid = aw_valid && lite;
  assign ml_wdata   = w_data;
  assign ml_wstrb   = '1;
  assign ml_wvalid  = w_valid && lite;
  assign ml_bready  = b_ready && lite;
  assign ml_araddr  = ax_addr;
  assign ml_arvalid = ar_valid && lite;
  assign ml_rready  = r_ready && lite;

  p_one_port_r11: assert property (@(posedge clk) disable iff (rst)
    !((m4_awvalid || m4_wvalid || m4_arvalid || m4_rready || m4_bready) &&
      (ml_awvalid || ml_wvalid || ml_arvalid || ml_rready || ml_bready)));
  p_no_input_while_bus_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (m4_bready || ml_bready || m4_rready || ml_rready) |-> !s_tready);
  p_ar_hold_r6: assert property (@(posedge clk) disable iff (rst)
    m4_arvalid && !m4_arready |=> m4_arvalid && $stable(m4_araddr) && $stable(m4_arlen));
  p_rready_gated_r8: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready && m_tdata != 8'h00 |-> !(m4_rready && m4_rvalid && !(ml_rready)) || !m_tvalid || m_tready);
endmodule

// File: tb/bytecmd_axi_bridge_test.sv
`timescale 1ns/1ps
module bytecmd_axi_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic        err_flag;
  logic [31:0] m4_awaddr, m4_wdata, m4_araddr, m4_rdata;
  logic [7:0]  m4_awlen, m4_arlen;
  logic [2:0]  m4_awsize, m4_arsize;
  logic [1:0]  m4_awburst, m4_arburst, m4_bresp;
  logic [3:0]  m4_wstrb, ml_wstrb;
  logic        m4_awvalid, m4_awready, m4_wlast, m4_wvalid, m4_wready, m4_bvalid, m4_bready;
  logic        m4_arvalid, m4_arready, m4_rlast, m4_rvalid, m4_rready;
  logic [31:0] ml_awaddr, ml_wdata, ml_araddr, ml_rdata;
  logic [1:0]  ml_bresp;
  logic        ml_awvalid, ml_awready, ml_wvalid, ml_wready, ml_bvalid, ml_bready;
  logic        ml_arvalid, ml_arready, ml_rvalid, ml_rready;

  bytecmd_axi_bridge uut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, stall_m = 0;
  logic [7:0]  exp_q[$];
  logic [31:0] sh4[64], shl[64];
  int aw4_cnt = 0, w4_cnt = 0, ar4_cnt = 0, awl_cnt = 0, wl_cnt = 0, arl_cnt = 0;
  int wlast_bad = 0, strb_bad = 0;
  logic [7:0] l_awlen, l_arlen;
  logic [2:0] l_awsize, l_arsize;
  logic [1:0] l_awburst, l_arburst;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int widx(input logic [31:0] a, input int beat);
    return (int'(a[7:2]) + beat) % 64;
  endfunction

  // AXI4 slave model
  initial begin : slave4
    logic [31:0] mem[64];
    logic [31:0] wbase, rbase;
    int wlen, wbeat, rlen, rbeat;
    bit bpend, ract;
    logic [1:0] bres;
    foreach (mem[i]) mem[i] = '0;
    bpend = 0; ract = 0; bres = 0; wbase = 0; rbase = 0;
    wlen = 0; wbeat = 0; rlen = 0; rbeat = 0;
    m4_awready = 1; m4_arready = 1; m4_wready = 0; m4_bvalid = 0; m4_bresp = 0;
    m4_rvalid = 0; m4_rdata = 0; m4_rlast = 0;
    forever begin
      @(negedge clk);
      m4_wready = (cyc % 2 == 0);
      m4_bvalid = bpend; m4_bresp = bres;
      m4_rvalid = ract; m4_rdata = mem[widx(rbase, rbeat)]; m4_rlast = (rbeat == rlen);
      #1;
      if (m4_awvalid && m4_awready) begin
        wbase = m4_awaddr; wlen = m4_awlen; wbeat = 0; aw4_cnt++;
        l_awlen = m4_awlen; l_awsize = m4_awsize; l_awburst = m4_awburst;
      end
      if (m4_wvalid && m4_wready) begin
        mem[widx(wbase, wbeat)] = m4_wdata; w4_cnt++;
        if (m4_wlast != (wbeat == wlen)) wlast_bad++;
        if (m4_wstrb != 4'hf) strb_bad++;
        if (wbeat == wlen) begin bpend = 1; bres = wbase[31] ? 2'b10 : 2'b00; end
        wbeat++;
      end
      if (m4_bvalid && m4_bready) bpend = 0;
      if (m4_arvalid && m4_arready) begin
        rbase = m4_araddr; rlen = m4_arlen; rbeat = 0; ract = 1; ar4_cnt++;
        l_arlen = m4_arlen; l_arsize = m4_arsize; l_arburst = m4_arburst;
      end
      if (m4_rvalid && m4_rready) begin
        if (rbeat == rlen) ract = 0;
        rbeat++;
      end
    end
  end

  // AXI4-Lite slave model
  initial begin : slavel
    logic [31:0] mem[64];
    logic [31:0] wbase, rbase;
    bit bpend, ract;
    foreach (mem[i]) mem[i] = '0;
    bpend = 0; ract = 0; wbase = 0; rbase = 0;
    ml_awready = 1; ml_arready = 1; ml_wready = 0; ml_bvalid = 0; ml_bresp = 0;
    ml_rvalid = 0; ml_rdata = 0;
    forever begin
      @(negedge clk);
      ml_wready = (cyc % 3 != 0);
      ml_bvalid = bpend; ml_bresp = 2'b00;
      ml_rvalid = ract; ml_rdata = mem[widx(rbase, 0)];
      #1;
      if (ml_awvalid && ml_awready) begin wbase = ml_awaddr; awl_cnt++; end
      if (ml_wvalid && ml_wready) begin
        mem[widx(wbase, 0)] = ml_wdata; wl_cnt++; bpend = 1;
        if (ml_wstrb != 4'hf) strb_bad++;
      end
      if (ml_bvalid && ml_bready) bpend = 0;
      if (ml_arvalid && ml_arready) begin rbase = ml_araddr; ract = 1; arl_cnt++; end
      if (ml_rvalid && ml_rready) ract = 0;
    end
  end

  // output sink and scoreboard monitor
  initial begin : monitor
    logic [7:0] e;
    forever begin
      @(negedge clk);
      m_tready = (stall_m == 0) ? 1'b1 : (stall_m == 1) ? (cyc % 3 != 0) : 1'b0;
      #1;
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected output byte", {24'h0, m_tdata}, 32'h0);
        else begin
          e = exp_q.pop_front();
          chk(m_tdata == e, "R4/R6 output byte order", {24'h0, m_tdata}, {24'h0, e});
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    s_tdata = b; s_tvalid = 1'b1;
    #1;
    while (!s_tready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_tvalid = 1'b0;
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [31:0] a, input logic [7:0] len);
    send_byte(op);
    for (int i = 3; i >= 0; i--) send_byte(a[i*8 +: 8]);
    send_byte(len);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
  endtask

  task automatic push_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) exp_q.push_back(w[i*8 +: 8]);
  endtask

  task automatic wait_done();
    @(negedge clk); #1;
    while (!(s_tready && exp_q.size() == 0)) begin @(negedge clk); #1; end
    repeat (2) @(negedge clk);
  endtask

  task automatic lite_write(input logic [31:0] a, input logic [31:0] d, input logic [7:0] len);
    send_hdr(8'h01, a, len);
    send_word(d);
    shl[widx(a, 0)] = d;
    wait_done();
  endtask

  task automatic lite_read(input logic [31:0] a);
    push_word(shl[widx(a, 0)]);
    send_hdr(8'h02, a, 8'h00);
    wait_done();
  endtask

  task automatic burst_write(input logic [31:0] a, input int n, input logic [31:0] seed);
    send_hdr(8'h03, a, 8'(n - 1));
    for (int i = 0; i < n; i++) begin
      send_word(seed + 32'h01020304 * i);
      sh4[widx(a, i)] = seed + 32'h01020304 * i;
    end
    wait_done();
  endtask

  task automatic burst_read(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) push_word(sh4[widx(a, i)]);
    send_hdr(8'h04, a, 8'(n - 1));
    wait_done();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog expired actual=hung expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    int a0, w0, r0;
    logic [7:0] held;
    foreach (sh4[i]) sh4[i] = '0;
    foreach (shl[i]) shl[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R10 reset state
    chk(s_tready == 1'b1, "R10 input ready after reset", {31'h0, s_tready}, 32'h1);
    chk(m_tvalid == 1'b0, "R10 output empty after reset", {31'h0, m_tvalid}, 32'h0);
    chk(err_flag == 1'b0, "R10 error low after reset", {31'h0, err_flag}, 32'h0);
    chk(!(m4_awvalid || m4_arvalid || m4_wvalid || ml_awvalid || ml_arvalid || ml_wvalid),
        "R10 no master valid after reset", 32'h0, 32'h0);

    // R1 unknown opcode dropped, parser still takes opcodes
    send_byte(8'h77);
    #1;
    chk(s_tready == 1'b1, "R1 unknown opcode dropped", {31'h0, s_tready}, 32'h1);
    chk(awl_cnt + arl_cnt + aw4_cnt + ar4_cnt == 0, "R1 no bus traffic for unknown opcode",
        32'(awl_cnt + arl_cnt + aw4_cnt + ar4_cnt), 32'h0);
    lite_write(32'h0000_0008, 32'hA5C3_1234, 8'h00);   // R2 byte order checked on readback
    lite_read(32'h0000_0008);                          // R4

    // R3 length byte ignored on Lite commands
    a0 = awl_cnt; w0 = wl_cnt;
    lite_write(32'h0000_000C, 32'hDEAD_BEEF, 8'h05);
    chk(awl_cnt - a0 == 1, "R3 one Lite AW", 32'(awl_cnt - a0), 32'h1);
    chk(wl_cnt - w0 == 1, "R3 one Lite W", 32'(wl_cnt - w0), 32'h1);
    r0 = arl_cnt;
    lite_read(32'h0000_000C);
    chk(arl_cnt - r0 == 1, "R4 one Lite AR", 32'(arl_cnt - r0), 32'h1);
    chk(aw4_cnt + ar4_cnt + w4_cnt == 0, "R11 AXI4 port idle during Lite", 32'(aw4_cnt + ar4_cnt + w4_cnt), 32'h0);

    // R5 burst write of 8 words
    a0 = awl_cnt;
    burst_write(32'h0000_0040, 8, 32'h1122_3340);
    chk(l_awlen == 8'd7, "R5 AWLEN", {24'h0, l_awlen}, 32'd7);
    chk(l_awburst == 2'b01, "R5 AWBURST", {30'h0, l_awburst}, 32'h1);
    chk(l_awsize == 3'd2, "R5 AWSIZE", {29'h0, l_awsize}, 32'h2);
    chk(w4_cnt == 8, "R5 beat count", 32'(w4_cnt), 32'd8);
    chk(wlast_bad == 0, "R5 WLAST placement", 32'(wlast_bad), 32'h0);
    chk(strb_bad == 0, "R3/R5 strobes all set", 32'(strb_bad), 32'h0);
    chk(awl_cnt == a0, "R11 Lite port idle during burst", 32'(awl_cnt), 32'(a0));

    // R6 burst read with a toggling sink
    stall_m = 1;
    burst_read(32'h0000_0040, 8);
    chk(l_arlen == 8'd7, "R6 ARLEN", {24'h0, l_arlen}, 32'd7);
    chk(l_arburst == 2'b01 && l_arsize == 3'd2, "R6 ARBURST/ARSIZE", {27'h0, l_arsize, l_arburst}, {27'h0, 3'd2, 2'b01});

    // R7/R8 sink fully stalled during a 4-beat read
    stall_m = 2;
    for (int i = 0; i < 4; i++) push_word(sh4[widx(32'h44, i)]);
    send_hdr(8'h04, 32'h0000_0044, 8'd3);
    repeat (20) @(negedge clk);
    #1;
    chk(s_tready == 1'b0, "R7 input held off during read", {31'h0, s_tready}, 32'h0);
    chk(m4_rready == 1'b0, "R8 RREADY low while buffer full", {31'h0, m4_rready}, 32'h0);
    chk(m_tvalid == 1'b1, "R8 byte waiting", {31'h0, m_tvalid}, 32'h1);
    held = m_tdata;
    @(negedge clk); #1;
    chk(m_tdata == held, "R8 byte stable under back-pressure", {24'h0, m_tdata}, {24'h0, held});
    stall_m = 0;
    wait_done();

    // back-to-back reads, second header while first still drains
    stall_m = 1;
    for (int i = 0; i < 3; i++) push_word(sh4[widx(32'h48, i)]);
    push_word(shl[widx(32'h8, 0)]);
    send_hdr(8'h04, 32'h0000_0048, 8'd2);
    send_hdr(8'h02, 32'h0000_0008, 8'd0);
    wait_done();
    stall_m = 0;

    // R5 single-beat burst boundary
    w0 = w4_cnt;
    burst_write(32'h0000_0080, 1, 32'h0BAD_F00D);
    chk(l_awlen == 8'd0, "R5 zero length AWLEN", {24'h0, l_awlen}, 32'h0);
    chk(w4_cnt - w0 == 1 && wlast_bad == 0, "R5 zero length one beat with WLAST", 32'(w4_cnt - w0), 32'h1);
    burst_read(32'h0000_0080, 1);

    // R9 sticky error
    chk(err_flag == 1'b0, "R9 error low before bad response", {31'h0, err_flag}, 32'h0);
    burst_write(32'h8000_0010, 2, 32'h5555_0000);
    chk(err_flag == 1'b1, "R9 error set by SLVERR", {31'h0, err_flag}, 32'h1);
    lite_write(32'h0000_0010, 32'h0000_0001, 8'h00);
    chk(err_flag == 1'b1, "R9 error stays set", {31'h0, err_flag}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule